// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block switches power domains on and off under software control. Each domain has its own 128-byte register window and its own sequencer. Software writes a command word to request power-on or power-off. The sequencer then steps the domain's power switch, isolation gate, clock enable and reset through a fixed order, and it waits a programmable number of cycles at the points where the real hardware needs analog settling time. The real switches are outside this block; only their control levels and the settling counts are modelled here.

Software checks progress by polling a status word. The status word has a busy bit, a sticky completion flag and a two-bit field that gives the present state. The completion flag stays set until software writes the status word back with that bit set. Two further read-only words show the live levels of the domain's control outputs. The number of domains is a parameter. Domain `i` is decoded at byte address `0x80*i`.

Top module: `pds_ctrl`

## Requirements
- R1: After reset, every domain is off. Its status word reads 0x0002_0000: state field (bits 17:16) = 2, busy (bit 3) = 0, completion (bit 1) = 0. Its isolation output is high and its reset-n, clock-enable and switch outputs are low. The switch delay reads 4, the off delay reads 3 and the on delay reads 2.
- R2: When a domain is off, writing 1 to its command word (offset 0x20) closes the switch at the write edge. Isolation is released after the switch delay (offset 0x14, in cycles). The clock is enabled one cycle later. Reset-n is released after the on delay (offset 0x1C). Busy is high for switch delay + on delay + 1 cycles.
- R3: Reset-n rises only while the switch is closed, isolation is released and the clock is enabled. The clock enable rises only while the switch is closed, isolation is released and reset-n is still low.
- R4: When a domain is on, writing 2 to its command word drives reset-n low at the write edge. The clock is gated one cycle later and isolation is asserted one cycle after that. The switch opens after the off delay (offset 0x18). Busy is high for off delay + 2 cycles. When the switch opens, reset-n is low, the clock is gated and isolation is high.
- R5: Busy falls at the same edge where completion (status bit 1) is set. At that edge the state field (bits 17:16) takes the requested value: 1 for on, 2 for off. The state field never holds any other value.
- R6: A command equal to the present state sets completion at the write edge. Busy stays low and no output changes.
- R7: A command word written while busy is ignored. A command word whose full 32-bit value is neither 1 nor 2 is also ignored. Neither one sets completion or changes the state or the outputs.
- R8: Completion stays set until the status word (offset 0x24) is written with bit 1 set. A status write with bit 1 clear leaves it set.
- R9: If a clearing status write and a sequence completion fall on the same edge, completion ends up set.
- R10: Each delay word can be written and read back. A delay value of 0 behaves exactly like 1.
- R11: Each domain's window is independent of the others. Offsets that are not mapped read 0. A window index at or above the number of domains reads 0, and writes to it have no effect.
- R12: Offset 0x30 reads reset-n on bit 0, clock enable on bit 1 and isolation on bit 2. Offset 0x34 reads the switch-closed level on bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address: upper bits select the domain window, low 7 bits the offset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| dom_rst_n | output | NUM_DOM | Per-domain reset, active low |
| dom_clk_en | output | NUM_DOM | Per-domain clock enable |
| dom_iso | output | NUM_DOM | Per-domain isolation (power-off gate), active high |
| dom_psw_on | output | NUM_DOM | Per-domain power switch closed |

## Verification
Two events can land on the same edge: the sequencer setting completion on its last step, and a software write that clears completion. The bench starts a power-on with known delays. It then counts cycles from the command write so that the clearing status write lands exactly on the completion edge. After that edge it expects completion set, busy low and the state field at 1. A second clearing write one cycle later must then leave completion at 0. This control case shows that the clear path itself still works.

// File: rtl/pds_pkg.sv
// Package: shared constants for the power domain sequencer.
// Assumes a 32-bit register bus and 128-byte per-domain windows.
package pds_pkg;
    localparam int DATA_W   = 32;
    localparam int WIN_BITS = 7;

    localparam logic [WIN_BITS-1:0] OFS_SW_DLY  = 7'h14;
    localparam logic [WIN_BITS-1:0] OFS_OFF_DLY = 7'h18;
    localparam logic [WIN_BITS-1:0] OFS_ON_DLY  = 7'h1C;
    localparam logic [WIN_BITS-1:0] OFS_CMD     = 7'h20;
    localparam logic [WIN_BITS-1:0] OFS_STAT    = 7'h24;
    localparam logic [WIN_BITS-1:0] OFS_GATE    = 7'h30;
    localparam logic [WIN_BITS-1:0] OFS_PSW     = 7'h34;

    localparam logic [1:0] ST_ON  = 2'd1;
    localparam logic [1:0] ST_OFF = 2'd2;

    localparam int STAT_DONE_BIT  = 1;
    localparam int STAT_BUSY_BIT  = 3;
    localparam int STAT_STATE_LSB = 16;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ON_SWWAIT,
        SQ_ON_CLK,
        SQ_ON_WAIT,
        SQ_OFF_CLK,
        SQ_OFF_ISO,
        SQ_OFF_WAIT
    } seq_e;
endpackage

// File: rtl/pds_regs.sv
// Module: per-domain register window. Holds the delay words, decodes
// command and status writes into pulses, and muxes read data.
// Assumes sel is already qualified by the window index; reads are
// combinational and return zero when not selected.
module pds_regs
    import pds_pkg::*;
#(
    parameter int DLY_W       = 8,
    parameter int SW_DLY_RST  = 4,
    parameter int OFF_DLY_RST = 3,
    parameter int ON_DLY_RST  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic                wr_en,
    input  logic [WIN_BITS-1:0] ofs,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                busy,
    input  logic                done,
    input  logic [1:0]          cur_state,
    input  logic                lvl_rst_n,
    input  logic                lvl_clk_en,
    input  logic                lvl_iso,
    input  logic                lvl_psw,
    output logic [DATA_W-1:0]   rdata,
    output logic [DLY_W-1:0]    sw_dly,
    output logic [DLY_W-1:0]    off_dly,
    output logic [DLY_W-1:0]    on_dly,
    output logic                req_on,
    output logic                req_off,
    output logic                done_clr
);
    logic wr_sel;

    // Qualified write strobe for this window.
    assign wr_sel = sel && wr_en;

    // Command and completion-clear pulses; only the two legal encodings count.
    always_comb begin
        req_on   = wr_sel && (ofs == OFS_CMD) && (wdata == DATA_W'(ST_ON));
        req_off  = wr_sel && (ofs == OFS_CMD) && (wdata == DATA_W'(ST_OFF));
        done_clr = wr_sel && (ofs == OFS_STAT) && wdata[STAT_DONE_BIT];
    end

    // Delay word storage with nonzero reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_dly  <= DLY_W'(SW_DLY_RST);
            off_dly <= DLY_W'(OFF_DLY_RST);
            on_dly  <= DLY_W'(ON_DLY_RST);
        end else if (wr_sel) begin
            if (ofs == OFS_SW_DLY)  sw_dly  <= wdata[DLY_W-1:0];
            if (ofs == OFS_OFF_DLY) off_dly <= wdata[DLY_W-1:0];
            if (ofs == OFS_ON_DLY)  on_dly  <= wdata[DLY_W-1:0];
        end
    end

    // Read multiplexer by offset.
    always_comb begin
        rdata = '0;
        if (sel) begin
            case (ofs)
                OFS_SW_DLY:  rdata = DATA_W'(sw_dly);
                OFS_OFF_DLY: rdata = DATA_W'(off_dly);
                OFS_ON_DLY:  rdata = DATA_W'(on_dly);
                OFS_STAT: begin
                    rdata[STAT_DONE_BIT] = done;
                    rdata[STAT_BUSY_BIT] = busy;
                    rdata[STAT_STATE_LSB +: 2] = cur_state;
                end
                OFS_GATE: rdata[2:0] = {lvl_iso, lvl_clk_en, lvl_rst_n};
                OFS_PSW:  rdata[0] = lvl_psw;
                default:  rdata = '0;
            endcase
        end
    end

    // Same-cycle command pulses must be mutually exclusive (R7 decode).
    assert_req_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_on && req_off));
endmodule

// File: rtl/pds_seq.sv
// Module: one domain's power sequencer. Accepts on/off requests when
// idle, steps the control levels in order with counted waits, and keeps
// the sticky completion flag. Assumes single-cycle request pulses.
module pds_seq
    import pds_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_on,
    input  logic             req_off,
    input  logic             done_clr,
    input  logic [DLY_W-1:0] sw_dly,
    input  logic [DLY_W-1:0] on_dly,
    input  logic [DLY_W-1:0] off_dly,
    output logic             busy,
    output logic             done,
    output logic [1:0]       cur_state,
    output logic             dom_rst_n,
    output logic             dom_clk_en,
    output logic             dom_iso,
    output logic             dom_psw
);
    seq_e             state;
    logic [DLY_W-1:0] cnt;
    logic             cnt_end;

    // Wait ends when the count is at one or below (zero behaves as one).
    assign cnt_end = (cnt <= DLY_W'(1));

    // Sequencer state, control levels and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            cnt        <= '0;
            busy       <= 1'b0;
            done       <= 1'b0;
            cur_state  <= ST_OFF;
            dom_rst_n  <= 1'b0;
            dom_clk_en <= 1'b0;
            dom_iso    <= 1'b1;
            dom_psw    <= 1'b0;
        end else begin
            if (done_clr) done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (req_on) begin
                        if (cur_state == ST_ON) begin
                            done <= 1'b1;
                        end else begin
                            dom_psw <= 1'b1;
                            cnt     <= sw_dly;
                            busy    <= 1'b1;
                            state   <= SQ_ON_SWWAIT;
                        end
                    end else if (req_off) begin
                        if (cur_state == ST_OFF) begin
                            done <= 1'b1;
                        end else begin
                            dom_rst_n <= 1'b0;
                            busy      <= 1'b1;
                            state     <= SQ_OFF_CLK;
                        end
                    end
                end
                SQ_ON_SWWAIT: begin
                    if (cnt_end) begin
                        dom_iso <= 1'b0;
                        state   <= SQ_ON_CLK;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SQ_ON_CLK: begin
                    dom_clk_en <= 1'b1;
                    cnt        <= on_dly;
                    state      <= SQ_ON_WAIT;
                end
                SQ_ON_WAIT: begin
                    if (cnt_end) begin
                        dom_rst_n <= 1'b1;
                        busy      <= 1'b0;
                        done      <= 1'b1;
                        cur_state <= ST_ON;
                        state     <= SQ_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SQ_OFF_CLK: begin
                    dom_clk_en <= 1'b0;
                    state      <= SQ_OFF_ISO;
                end
                SQ_OFF_ISO: begin
                    dom_iso <= 1'b1;
                    cnt     <= off_dly;
                    state   <= SQ_OFF_WAIT;
                end
                SQ_OFF_WAIT: begin
                    if (cnt_end) begin
                        dom_psw   <= 1'b0;
                        busy      <= 1'b0;
                        done      <= 1'b1;
                        cur_state <= ST_OFF;
                        state     <= SQ_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assert_busy_fall_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    assert_state_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_ON) || (cur_state == ST_OFF));
    assert_rst_release_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_rst_n) |-> (dom_clk_en && !dom_iso && dom_psw));
    assert_clk_enable_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_clk_en) |-> (dom_psw && !dom_iso && !dom_rst_n));
    assert_switch_open_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_psw) |-> (!dom_rst_n && !dom_clk_en && dom_iso));
    assert_same_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_on && (cur_state == ST_ON)) |=> (!busy && done));
    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (req_on || req_off)) |=> (busy || done));
endmodule

// File: rtl/pds_ctrl.sv
// Module: top of the power domain sequencing controller. Splits the byte
// address into a window index and an offset, instantiates one register
// window and one sequencer per domain, and ORs the read data.
// Assumes ADDR_W > 7 and NUM_DOM <= 2**(ADDR_W-7).
module pds_ctrl
    import pds_pkg::*;
#(
    parameter int NUM_DOM     = 3,
    parameter int ADDR_W      = 10,
    parameter int DLY_W       = 8,
    parameter int SW_DLY_RST  = 4,
    parameter int OFF_DLY_RST = 3,
    parameter int ON_DLY_RST  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_DOM-1:0] dom_rst_n,
    output logic [NUM_DOM-1:0] dom_clk_en,
    output logic [NUM_DOM-1:0] dom_iso,
    output logic [NUM_DOM-1:0] dom_psw_on
);
    localparam int IDX_W = ADDR_W - WIN_BITS;

    logic [IDX_W-1:0]    win_idx;
    logic [WIN_BITS-1:0] win_ofs;
    logic [DATA_W-1:0]   rd_vec [NUM_DOM];

    // Address split into window index and in-window offset.
    assign win_idx = bus_addr[ADDR_W-1:WIN_BITS];
    assign win_ofs = bus_addr[WIN_BITS-1:0];

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        logic             sel;
        logic [DLY_W-1:0] sw_dly, off_dly, on_dly;
        logic             req_on, req_off, done_clr;
        logic             busy, done;
        logic [1:0]       cur_state;

        assign sel = (win_idx == IDX_W'(g));

        pds_regs #(
            .DLY_W(DLY_W), .SW_DLY_RST(SW_DLY_RST),
            .OFF_DLY_RST(OFF_DLY_RST), .ON_DLY_RST(ON_DLY_RST)
        ) u_regs (
            .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(bus_we),
            .ofs(win_ofs), .wdata(bus_wdata),
            .busy(busy), .done(done), .cur_state(cur_state),
            .lvl_rst_n(dom_rst_n[g]), .lvl_clk_en(dom_clk_en[g]),
            .lvl_iso(dom_iso[g]), .lvl_psw(dom_psw_on[g]),
            .rdata(rd_vec[g]), .sw_dly(sw_dly), .off_dly(off_dly),
            .on_dly(on_dly), .req_on(req_on), .req_off(req_off),
            .done_clr(done_clr)
        );

        pds_seq #(.DLY_W(DLY_W)) u_seq (
            .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off),
            .done_clr(done_clr), .sw_dly(sw_dly), .on_dly(on_dly),
            .off_dly(off_dly), .busy(busy), .done(done),
            .cur_state(cur_state), .dom_rst_n(dom_rst_n[g]),
            .dom_clk_en(dom_clk_en[g]), .dom_iso(dom_iso[g]),
            .dom_psw(dom_psw_on[g])
        );
    end

    // Combine per-window read data; unselected windows return zero.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_DOM; i++) bus_rdata = bus_rdata | rd_vec[i];
    end
endmodule

// File: tb/pds_ctrl_tb.sv
module pds_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] O_SW = 7'h14, O_OFF = 7'h18, O_ON = 7'h1C,
                           O_CMD = 7'h20, O_STAT = 7'h24, O_GATE = 7'h30,
                           O_PSW = 7'h34, O_HOLE = 7'h28;

    // Vector: dom(2) cmd(2) sw(8) on(8) off(8) busy cycles(8) end state(2)
    localparam int NVEC = 8;
    localparam logic [37:0] VECS [NVEC] = '{
        {2'd0, 2'd1, 8'd4, 8'd2, 8'd3, 8'd7, 2'd1},
        {2'd0, 2'd1, 8'd4, 8'd2, 8'd3, 8'd0, 2'd1},
        {2'd0, 2'd2, 8'd4, 8'd2, 8'd3, 8'd5, 2'd2},
        {2'd0, 2'd1, 8'd0, 8'd0, 8'd3, 8'd3, 2'd1},
        {2'd1, 2'd1, 8'd1, 8'd5, 8'd3, 8'd7, 2'd1},
        {2'd0, 2'd2, 8'd1, 8'd1, 8'd0, 8'd3, 2'd2},
        {2'd1, 2'd2, 8'd1, 8'd5, 8'd6, 8'd8, 2'd2},
        {2'd1, 2'd2, 8'd1, 8'd5, 8'd6, 8'd0, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  dom_rst_n, dom_clk_en, dom_iso, dom_psw_on;

    int total = 0;
    int bad = 0;

    pds_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dom_rst_n(dom_rst_n),
        .dom_clk_en(dom_clk_en), .dom_iso(dom_iso), .dom_psw_on(dom_psw_on)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [9:0] ad(input int dom, input logic [6:0] ofs);
        return 10'(dom * 128) + 10'(ofs);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_now(input logic [9:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_now(a, d);
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle(input int dom, output int n);
        logic [31:0] s;
        n = 0;
        rd(ad(dom, O_STAT), s);
        while (s[3] && n < 300) begin
            n++;
            @(negedge clk);
            rd(ad(dom, O_STAT), s);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(ad(0, O_STAT), d); chk("R1 status", d, 32'h0002_0000);
        rd(ad(0, O_SW), d);   chk("R1 sw delay", d, 4);
        rd(ad(0, O_OFF), d);  chk("R1 off delay", d, 3);
        rd(ad(0, O_ON), d);   chk("R1 on delay", d, 2);
        chk("R1 outputs", {dom_rst_n, dom_clk_en, dom_iso, dom_psw_on},
            {3'b000, 3'b000, 3'b111, 3'b000});

        // Vector table: sequencing lengths and end states (R2 R4 R5 R6 R10 R12)
        for (int v = 0; v < NVEC; v++) begin
            int dom;
            logic [1:0] st;
            dom = int'(VECS[v][37:36]);
            st  = VECS[v][1:0];
            wr(ad(dom, O_SW),  32'(VECS[v][33:26]));
            wr(ad(dom, O_ON),  32'(VECS[v][25:18]));
            wr(ad(dom, O_OFF), 32'(VECS[v][17:10]));
            wr(ad(dom, O_STAT), 32'h2);
            wr(ad(dom, O_CMD), 32'(VECS[v][35:34]));
            wait_idle(dom, n);
            chk("R2 R4 R6 R10 busy cycles", 32'(n), 32'(VECS[v][9:2]));
            rd(ad(dom, O_STAT), d);
            chk("R5 state field", 32'(d[17:16]), 32'(st));
            chk("R5 completion", 32'(d[1]), 1);
            rd(ad(dom, O_GATE), d);
            chk("R12 gate status", d, (st == 2'd1) ? 32'h3 : 32'h4);
            rd(ad(dom, O_PSW), d);
            chk("R12 switch status", d, (st == 2'd1) ? 32'h1 : 32'h0);
        end

        // R2 R3: cycle-level power-on with sw=2 on=3
        wr(ad(0, O_SW), 2); wr(ad(0, O_ON), 3); wr(ad(0, O_STAT), 2);
        wr(ad(0, O_CMD), 1);
        chk("R2 switch closes at write", {29'b0, dom_psw_on[0], dom_iso[0], dom_clk_en[0]}, 3'b110);
        @(negedge clk); @(negedge clk);
        chk("R2 iso released after sw delay", {30'b0, dom_iso[0], dom_clk_en[0]}, 2'b00);
        @(negedge clk);
        chk("R2 clock on next cycle", {30'b0, dom_clk_en[0], dom_rst_n[0]}, 2'b10);
        @(negedge clk); @(negedge clk);
        chk("R2 reset held during on delay", 32'(dom_rst_n[0]), 0);
        @(negedge clk);
        chk("R3 reset released last", {28'b0, dom_rst_n[0], dom_clk_en[0], dom_iso[0], dom_psw_on[0]}, 4'b1101);
        rd(ad(0, O_STAT), d); chk("R5 busy low done set", d, 32'h0001_0002);

        // R4: cycle-level power-off with off=2, plus commands while busy (R7)
        wr(ad(0, O_OFF), 2); wr(ad(0, O_STAT), 2);
        wr(ad(0, O_CMD), 2);
        chk("R4 reset at write", {30'b0, dom_rst_n[0], dom_clk_en[0]}, 2'b01);
        wr_now(ad(0, O_CMD), 1);
        chk("R4 clock gated", {30'b0, dom_clk_en[0], dom_iso[0]}, 2'b00);
        wr_now(ad(0, O_CMD), 2);
        chk("R4 iso asserted", {30'b0, dom_iso[0], dom_psw_on[0]}, 2'b11);
        @(negedge clk);
        chk("R4 switch held during off delay", 32'(dom_psw_on[0]), 1);
        @(negedge clk);
        chk("R4 switch opens", 32'(dom_psw_on[0]), 0);
        @(negedge clk); @(negedge clk);
        rd(ad(0, O_STAT), d);
        chk("R7 busy-time command ignored", d, 32'h0002_0002);

        // R7: illegal encodings while idle
        wr(ad(0, O_STAT), 2);
        wr(ad(0, O_CMD), 3); wr(ad(0, O_CMD), 0); wr(ad(0, O_CMD), 32'h101);
        @(negedge clk);
        rd(ad(0, O_STAT), d);
        chk("R7 illegal command ignored", d, 32'h0002_0000);
        chk("R7 outputs unchanged", {28'b0, dom_rst_n[0], dom_clk_en[0], dom_iso[0], dom_psw_on[0]}, 4'b0010);

        // R6 R8: same-state command, sticky completion and clear
        wr(ad(0, O_CMD), 2);
        rd(ad(0, O_STAT), d); chk("R6 same-state done, not busy", d, 32'h0002_0002);
        repeat (5) @(negedge clk);
        wr(ad(0, O_STAT), 0);
        wr(ad(0, O_STAT), 32'hFFFF_FFFD);
        rd(ad(0, O_STAT), d); chk("R8 completion sticky", 32'(d[1]), 1);
        wr(ad(0, O_STAT), 2);
        rd(ad(0, O_STAT), d); chk("R8 completion cleared", 32'(d[1]), 0);

        // R9: clear write on the completion edge (sw=1 on=1 -> 3 busy cycles)
        wr(ad(0, O_SW), 1); wr(ad(0, O_ON), 1);
        wr(ad(0, O_CMD), 1);
        @(negedge clk); @(negedge clk);
        wr_now(ad(0, O_STAT), 2);
        rd(ad(0, O_STAT), d); chk("R9 set wins over clear", d, 32'h0001_0002);
        wr_now(ad(0, O_STAT), 2);
        rd(ad(0, O_STAT), d); chk("R9 later clear works", d, 32'h0001_0000);

        // R10: delay readback
        wr(ad(1, O_OFF), 32'h5A);
        rd(ad(1, O_OFF), d); chk("R10 delay readback", d, 32'h5A);

        // R11: window independence and unmapped space
        rd(ad(0, O_HOLE), d); chk("R11 unmapped offset", d, 0);
        rd(ad(2, O_STAT), d); chk("R11 untouched domain", d, 32'h0002_0000);
        rd(ad(0, O_OFF), d);  chk("R11 window separation", d, 2);
        wr(ad(3, O_CMD), 1);
        @(negedge clk);
        rd(ad(3, O_STAT), d); chk("R11 index past range reads 0", d, 0);
        chk("R11 no domain moved", {20'b0, dom_rst_n, dom_clk_en, dom_iso, dom_psw_on},
            {3'b001, 3'b001, 3'b110, 3'b001});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule